// File: doc/BRIEF.md
# Toggle-Index Compressed Table Decoder

This block returns one word of a small precomputed lookup table (here the partial-sum table of a three-tap distributed-arithmetic filter) without storing the full table. The table is split into bit columns. A column whose value flips at most twice from one entry to the next is held as a starting bit and up to two flip addresses. Its output bit is rebuilt by comparing the requested address against those flip addresses. Every other column is held as-is in a narrow raw ROM. A per-column select merges the two paths into the output word. The encoding is worked out at elaboration from the table definition. A flip address in the lower half of the table is kept one bit narrower than one in the upper half.

Requests arrive as an address with a valid/ready handshake. Each request produces one word on a registered output stream with its own valid/ready handshake. The block accepts a request in any cycle where the output register is empty or is being drained. While the output is valid and the consumer holds `out_ready` low, the output word and its valid stay frozen and `in_ready` is low. Requests are not lost under back-pressure: a request is taken only when `in_valid` and `in_ready` are both high.

Top module: `cld_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An address taken with `in_valid && in_ready` at a rising edge appears on `out_data` with `out_valid` high right after that edge. The word equals T[a] = (0xFB + 1·a[0] + 2·a[1] + 4·a[2]) mod 256, for addresses 0 to 7.
- R3: Bits 7 to 3 come from single-flip columns: each is 1 for addresses below 5 and 0 from address 5 upward.
- R4: Bit 2 comes from a two-flip column: it is 0 at address 0, 1 for addresses 1 to 4, and 0 for addresses 5 to 7.
- R5: Bits 1 and 0 are taken from the raw ROM. They equal bits 1 and 0 of T[a].
- R6: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. In that state `out_valid` and `out_data` keep their values at every edge.
- R7: When the output is drained (`out_valid && out_ready`) and no request is taken, `out_valid` is 0 after the edge.
- R8: Requests presented on consecutive cycles with `out_ready` high are all accepted, one per cycle, and come out in the same order.
- R9: `in_addr` has no effect unless a request is taken. With `in_valid` low, or with `in_ready` low, the output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_addr | input | 3 | Table address of the request |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 8 | Reconstructed table word |

## Verification
Every address is first sent as an isolated request. This compares the whole word and, separately, each column group (single-flip, two-flip, raw). A fault in one decode path then shows up apart from the others. A back-to-back burst over all addresses separates a correct one-per-cycle pipeline from one that drops or reorders requests. A stall with a changing address shows that back-pressure freezes the output and blocks intake. Idle cycles with changing addresses and `in_valid` low show that unaccepted addresses leave the output untouched.

// File: rtl/cld_pkg.sv
package cld_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = DEPTH / 2;

  // Table: offset plus the taps selected by each address bit.
  localparam logic [DATA_W-1:0] BASE = 8'hFB;
  localparam logic [ADDR_W-1:0][DATA_W-1:0] TAPS = {8'd4, 8'd2, 8'd1};

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic            raw;
    logic            start;
    logic [1:0]      nflip;
    logic [ADDR_W:0] pos1;
    logic [ADDR_W:0] pos2;
  } col_code_t;

  function automatic word_t table_word(input int a);
    word_t acc;
    acc = BASE;
    for (int k = 0; k < ADDR_W; k++)
      if (((a >> k) & 1) == 1) acc = acc + TAPS[k];
    return acc;
  endfunction

  function automatic col_code_t encode_col(input int c);
    col_code_t r;
    word_t     w;
    logic      prev;
    int        n;
    w       = table_word(0);
    r.start = w[c];
    r.pos1  = (ADDR_W+1)'(DEPTH);
    r.pos2  = (ADDR_W+1)'(DEPTH);
    prev    = w[c];
    n       = 0;
    for (int a = 1; a < DEPTH; a++) begin
      w = table_word(a);
      if (w[c] != prev) begin
        n = n + 1;
        if (n == 1) r.pos1 = (ADDR_W+1)'(a);
        else if (n == 2) r.pos2 = (ADDR_W+1)'(a);
        prev = w[c];
      end
    end
    r.raw   = (n > 2);
    r.nflip = (n > 2) ? 2'd3 : 2'(n);
    return r;
  endfunction

  function automatic word_t raw_mask();
    word_t     m;
    col_code_t cc;
    for (int c = 0; c < DATA_W; c++) begin
      cc   = encode_col(c);
      m[c] = cc.raw;
    end
    return m;
  endfunction

  function automatic logic [DEPTH-1:0] column_bits(input int c);
    logic [DEPTH-1:0] v;
    word_t            w;
    for (int a = 0; a < DEPTH; a++) begin
      w    = table_word(a);
      v[a] = w[c];
    end
    return v;
  endfunction

  // Narrow form: a flip address in the lower half drops its top bit.
  function automatic int pos_bits(input int p);
    return (p < HALF) ? ADDR_W - 1 : ADDR_W;
  endfunction

endpackage

// File: rtl/cld_col_cmp.sv
module cld_col_cmp #(
  parameter int   ADDR_W = cld_pkg::ADDR_W,
  parameter logic START  = 1'b0,
  parameter int   NFLIP  = 0,
  parameter int   POS1   = 0,
  parameter int   POS2   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bit_o
);

  generate
    if (NFLIP == 0) begin : g_const
      assign bit_o = START;
    end else begin : g_cmp
      localparam int W1 = cld_pkg::pos_bits(POS1);
      localparam logic [W1-1:0] STORED1 = W1'(POS1);
      logic ge1;
      assign ge1 = ({1'b0, addr} >= (ADDR_W+1)'(STORED1));
      if (NFLIP == 1) begin : g_one
        assign bit_o = START ^ ge1;
        always_comb begin
          p_below_first_r3: assert (!(int'(addr) < POS1) || bit_o == START);
        end
      end else begin : g_two
        localparam int W2 = cld_pkg::pos_bits(POS2);
        localparam logic [W2-1:0] STORED2 = W2'(POS2);
        logic ge2;
        assign ge2   = ({1'b0, addr} >= (ADDR_W+1)'(STORED2));
        assign bit_o = START ^ ge1 ^ ge2;
        always_comb begin
          p_past_second_r4: assert (!(int'(addr) >= POS2) || bit_o == START);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cld_raw_rom.sv
module cld_raw_rom #(
  parameter int ADDR_W = cld_pkg::ADDR_W,
  parameter int DATA_W = cld_pkg::DATA_W,
  parameter logic [DATA_W-1:0] MASK = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word_o
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar c = 0; c < DATA_W; c++) begin : g_col
      if (MASK[c]) begin : g_store
        localparam logic [DEPTH-1:0] BITS = cld_pkg::column_bits(c);
        assign word_o[c] = BITS[addr];
      end else begin : g_none
        assign word_o[c] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/cld_decoder.sv
module cld_decoder #(
  parameter int ADDR_W = cld_pkg::ADDR_W,
  parameter int DATA_W = cld_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [DATA_W-1:0] RAW_MASK = cld_pkg::raw_mask();

  logic [DATA_W-1:0] raw_word;
  logic [DATA_W-1:0] cmp_word;
  logic [DATA_W-1:0] merged;

  cld_raw_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK(RAW_MASK)) u_raw (
    .addr   (in_addr),
    .word_o (raw_word)
  );

  generate
    for (genvar c = 0; c < DATA_W; c++) begin : g_col
      localparam cld_pkg::col_code_t CODE = cld_pkg::encode_col(c);
      if (CODE.raw) begin : g_raw
        assign cmp_word[c] = 1'b0;
      end else begin : g_cmp
        cld_col_cmp #(
          .ADDR_W (ADDR_W),
          .START  (CODE.start),
          .NFLIP  (int'(CODE.nflip)),
          .POS1   (int'(CODE.pos1)),
          .POS2   (int'(CODE.pos2))
        ) u_cmp (
          .addr  (in_addr),
          .bit_o (cmp_word[c])
        );
      end
    end
  endgenerate

  assign merged   = (raw_word & RAW_MASK) | (cmp_word & ~RAW_MASK);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= merged;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_drain_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && out_valid && !out_ready |=> $stable(out_data));

endmodule

// File: tb/sim_cld_decoder.sv
module sim_cld_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_addr = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cld_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [7:0] expect_word(input int a);
    int s;
    s = 251 + (a & 1) + 2 * ((a >> 1) & 1) + 4 * ((a >> 2) & 1);
    return 8'(s % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_word(input int a);
    logic [7:0] e;
    logic [4:0] hi;
    e  = expect_word(a);
    hi = (a < 5) ? 5'h1F : 5'h00;
    check("R2 valid", int'(out_valid), 1);
    check("R2 word", int'(out_data), int'(e));
    check("R3 single-flip bits", int'(out_data[7:3]), int'(hi));
    check("R4 two-flip bit", int'(out_data[2]), (a >= 1 && a <= 4) ? 1 : 0);
    check("R5 raw bits", int'(out_data[1:0]), int'(e[1:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 ready after reset", int'(in_ready), 1);

    // Isolated requests over every address
    for (int a = 0; a < 8; a++) begin
      in_valid = 1'b1; in_addr = 3'(a);
      @(negedge clk);
      in_valid = 1'b0;
      check_word(a);
      @(negedge clk);
      check("R7 drop after drain", int'(out_valid), 0);
    end

    // Back-to-back burst
    for (int a = 0; a <= 8; a++) begin
      if (a > 0) begin
        check("R8 burst valid", int'(out_valid), 1);
        check("R8 burst order", int'(out_data), int'(expect_word(a - 1)));
      end
      if (a < 8) begin
        in_valid = 1'b1; in_addr = 3'(7 - (a % 8) ^ 3'd2);
        in_addr = 3'(a);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check("R7 idle after burst", int'(out_valid), 0);

    // Idle with changing address
    for (int a = 0; a < 4; a++) begin
      in_addr = 3'(a * 3);
      @(negedge clk);
      check("R9 no request no output", int'(out_valid), 0);
    end

    // Stall
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 3'd2;
    @(negedge clk);
    in_addr = 3'd6;
    for (int i = 0; i < 3; i++) begin
      check("R6 ready low in stall", int'(in_ready), 0);
      check("R6 valid held", int'(out_valid), 1);
      check("R9 word held under stall", int'(out_data), int'(expect_word(2)));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R6 ready on drain", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 next word after stall", int'(out_data), int'(expect_word(6)));
    @(negedge clk);
    check("R7 idle after stall", int'(out_valid), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule